// File: doc/BRIEF.md
# DAC start-up initialization mute

This block sits in the stereo sample path just ahead of a DAC. It watches the DAC power-enable control together with the power controls of the two ADC channels. When the DAC is switched on while both ADC channels are off, the DAC needs an initialization period. For the length of that period the block sends digital silence to both DAC channels.

The period is measured in sample strobes, not in clock cycles. While it runs, the block also raises a hold flag for an automatic level control, provided that control is enabled. The level control then keeps the gain programmed in the input-volume register, and adapts from that gain once the period is over. If either ADC channel is powered at the moment the DAC is switched on, no initialization period is run and samples pass through at once.

Top module: `dac_init_mute`

## Requirements
- R1: After synchronous active-low reset, both output samples are 0, `init_busy` is 0 and `alc_hold` is 0.
- R2: A 0-to-1 change of `dac_pwr` while `adc_l_pwr` and `adc_r_pwr` are both 0 raises `init_busy` on the next clock edge.
- R3: The window covers exactly `INIT_LEN` sample strobes (default 1059). The output captured on each of those strobes is two's-complement zero on both channels. `init_busy` falls on the clock edge of the last of those strobes.
- R4: A 0-to-1 change of `dac_pwr` while either ADC power input is 1 starts no window. The input samples are passed through from the first strobe onward.
- R5: `alc_hold` is 1 exactly while `init_busy` is 1 and `alc_en` is 1.
- R6: When no window is running and `dac_pwr` is 1, each strobe registers `din_l` and `din_r` onto `dout_l` and `dout_r` on that clock edge. Between strobes the outputs hold their value.
- R7: While `dac_pwr` is 0, both outputs become 0 on the next clock edge and stay 0. A drop of `dac_pwr` during a window aborts the window, and the next power-up starts a fresh, full-length window.
- R8: The window count advances only on strobes. Clock cycles without a strobe do not shorten the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| dac_pwr | input | 1 | DAC power enable |
| adc_l_pwr | input | 1 | Left ADC channel power |
| adc_r_pwr | input | 1 | Right ADC channel power |
| alc_en | input | 1 | Level control enabled |
| din_l | input | SAMPLE_W | Left input sample, signed |
| din_r | input | SAMPLE_W | Right input sample, signed |
| dout_l | output | SAMPLE_W | Left output sample to the DAC |
| dout_r | output | SAMPLE_W | Right output sample to the DAC |
| init_busy | output | 1 | Initialization window running |
| alc_hold | output | 1 | Level control must hold the programmed gain |

## Verification
The hardest case to reach from the ports is the boundary at the end of the window. It lies 1059 strobes after the power-up edge, and the output must change on exactly the first strobe after the last muted one. The bench reaches it by powering up the full-length design under every combination of ADC power and level-control enable, and checking every strobe of each window. It also inserts a long strobe-free gap mid-window, to show that idle clocks do not count toward the window. A second hard case is an abort followed by a fresh power-up: the bench drops the DAC power partway through a window, then checks that the next window again lasts its full length.

// File: rtl/dim_pkg.sv
// Shared types for the DAC start-up mute block.
// Assumes: nothing beyond a two-state window controller.
package dim_pkg;
    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_RUN  = 1'b1
    } win_state_t;
endpackage

// File: rtl/dim_rise_detect.sv
// Detects a 0-to-1 change of a level input, one cycle wide.
// Assumes: the input is synchronous to clk. Reset treats the prior level as 0.
module dim_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    // register the previous level
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/dim_window_ctrl.sv
// Runs the initialization window: it starts on a DAC power-up with both ADC
// channels off and counts INIT_LEN strobes. A DAC power drop aborts it.
// Assumes: smp_stb is a one-cycle pulse.
module dim_window_ctrl
    import dim_pkg::*;
#(
    parameter int INIT_LEN = 1059
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_stb,
    input  logic dac_pwr,
    input  logic dac_rise,
    input  logic adc_l_pwr,
    input  logic adc_r_pwr,
    output logic busy,
    output logic start
);
    localparam int CNT_W = (INIT_LEN > 1) ? $clog2(INIT_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_LEN - 1);

    win_state_t       state;
    logic [CNT_W-1:0] cnt;

    assign start = dac_rise & ~adc_l_pwr & ~adc_r_pwr;
    assign busy  = (state == WIN_RUN);

    // window state and strobe counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WIN_IDLE;
            cnt   <= '0;
        end else if (!dac_pwr) begin
            state <= WIN_IDLE;
            cnt   <= '0;
        end else if (start) begin
            state <= WIN_RUN;
            cnt   <= '0;
        end else if (state == WIN_RUN && smp_stb) begin
            if (cnt == LAST) begin
                state <= WIN_IDLE;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_adc_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_rise && (adc_l_pwr || adc_r_pwr) && !busy) |=> !busy);
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= LAST));
    assert_no_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !smp_stb && dac_pwr && !start) |=> ($stable(cnt) && busy));
    assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_pwr |=> !busy);
endmodule

// File: rtl/dim_sample_gate.sv
// Output register for one channel. It captures the input on a strobe, or
// zero while muted, and clears at once while the DAC is off.
// Assumes: mute is valid in the strobe cycle.
module dim_sample_gate #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_stb,
    input  logic                dac_pwr,
    input  logic                mute,
    input  logic [SAMPLE_W-1:0] din,
    output logic [SAMPLE_W-1:0] dout
);
    // registered, gated sample
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (!dac_pwr) dout <= '0;
        else if (smp_stb)  dout <= mute ? '0 : din;
    end

    assert_mute_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && mute) |=> (dout == '0));
    assert_off_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_pwr |=> (dout == '0));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_stb && dac_pwr) |=> $stable(dout));
endmodule

// File: rtl/dac_init_mute.sv
// DAC start-up initialization mute. It forces both channels to zero for
// INIT_LEN sample strobes after a DAC power-up with both ADC channels off,
// and asks the level control to hold its gain meanwhile.
// Assumes: every input is synchronous to clk, and smp_stb is a one-cycle pulse.
module dac_init_mute #(
    parameter int SAMPLE_W = 16,
    parameter int INIT_LEN = 1059
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_stb,
    input  logic                dac_pwr,
    input  logic                adc_l_pwr,
    input  logic                adc_r_pwr,
    input  logic                alc_en,
    input  logic [SAMPLE_W-1:0] din_l,
    input  logic [SAMPLE_W-1:0] din_r,
    output logic [SAMPLE_W-1:0] dout_l,
    output logic [SAMPLE_W-1:0] dout_r,
    output logic                init_busy,
    output logic                alc_hold
);
    localparam int NCH = 2;

    logic                dac_rise;
    logic                busy;
    logic                start;
    logic                mute;
    logic [SAMPLE_W-1:0] din_ch  [NCH];
    logic [SAMPLE_W-1:0] dout_ch [NCH];

    dim_rise_detect u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (dac_pwr),
        .rise  (dac_rise)
    );

    dim_window_ctrl #(.INIT_LEN(INIT_LEN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .dac_pwr   (dac_pwr),
        .dac_rise  (dac_rise),
        .adc_l_pwr (adc_l_pwr),
        .adc_r_pwr (adc_r_pwr),
        .busy      (busy),
        .start     (start)
    );

    assign mute      = busy | start;
    assign din_ch[0] = din_l;
    assign din_ch[1] = din_r;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        dim_sample_gate #(.SAMPLE_W(SAMPLE_W)) u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_stb (smp_stb),
            .dac_pwr (dac_pwr),
            .mute    (mute),
            .din     (din_ch[ch]),
            .dout    (dout_ch[ch])
        );
    end

    assign dout_l    = dout_ch[0];
    assign dout_r    = dout_ch[1];
    assign init_busy = busy;
    assign alc_hold  = busy & alc_en;

    assert_hold_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && alc_en) |-> alc_hold);
endmodule

// File: tb/dac_init_mute_test.sv
module dac_init_mute_test;
    localparam int CLK_PERIOD = 10;
    localparam int SW  = 16;
    localparam int WIN = 1059;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_stb = 1'b0;
    logic dac_pwr = 1'b0;
    logic adc_l_pwr = 1'b0;
    logic adc_r_pwr = 1'b0;
    logic alc_en = 1'b0;
    logic [SW-1:0] din_l = '0;
    logic [SW-1:0] din_r = '0;
    logic [SW-1:0] dout_l, dout_r;
    logic init_busy, alc_hold;

    int total = 0;
    int bad = 0;
    bit done = 0;

    dac_init_mute uut (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .dac_pwr(dac_pwr),
        .adc_l_pwr(adc_l_pwr), .adc_r_pwr(adc_r_pwr), .alc_en(alc_en),
        .din_l(din_l), .din_r(din_r), .dout_l(dout_l), .dout_r(dout_r),
        .init_busy(init_busy), .alc_hold(alc_hold)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one strobe with index-derived nonzero data, output checked after the edge
    task automatic strobe(input int k, input bit exp_mute, input bit exp_busy,
                          input bit alc);
        logic [SW-1:0] l, r;
        l = SW'(16'h0100 + k * 7 + 1);
        r = SW'(16'h8000 | (k & 16'h7fff));
        @(negedge clk);
        smp_stb = 1'b1; din_l = l; din_r = r;
        @(negedge clk);
        smp_stb = 1'b0;
        if (exp_mute) begin
            chk("R3 mute left", 32'(dout_l), 32'(0));
            chk("R3 mute right", 32'(dout_r), 32'(0));
        end else begin
            chk("R6 pass left", 32'(dout_l), 32'(l));
            chk("R6 pass right", 32'(dout_r), 32'(r));
        end
        chk("R3 busy", 32'(init_busy), 32'(exp_busy));
        chk("R5 alc_hold", 32'(alc_hold), 32'(exp_busy & alc));
        @(negedge clk);
        chk("R6 hold between strobes", 32'(dout_l), exp_mute ? 32'(0) : 32'(l));
    endtask

    task automatic power_up(input bit al, input bit ar, input bit alc);
        bit win;
        win = !al && !ar;
        @(negedge clk);
        adc_l_pwr = al; adc_r_pwr = ar; alc_en = alc;
        @(negedge clk);
        dac_pwr = 1'b1;
        @(negedge clk);
        if (win) chk("R2 window start", 32'(init_busy), 32'(1));
        else     chk("R4 no window", 32'(init_busy), 32'(0));
        chk("R5 alc_hold at start", 32'(alc_hold), 32'(win & alc));
    endtask

    task automatic power_down;
        @(negedge clk);
        dac_pwr = 1'b0;
        @(negedge clk);
        chk("R7 off left zero", 32'(dout_l), 32'(0));
        chk("R7 off right zero", 32'(dout_r), 32'(0));
        chk("R7 off busy", 32'(init_busy), 32'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset left", 32'(dout_l), 32'(0));
        chk("R1 reset right", 32'(dout_r), 32'(0));
        chk("R1 reset busy", 32'(init_busy), 32'(0));
        chk("R1 reset hold", 32'(alc_hold), 32'(0));
        rst_n = 1'b1;

        // sweep every ADC power and level-control combination
        for (int c = 0; c < 8; c++) begin
            bit al, ar, alc, win;
            al = c[0]; ar = c[1]; alc = c[2];
            win = !al && !ar;
            power_up(al, ar, alc);
            for (int k = 0; k < WIN + 3; k++) begin
                if (c == 0 && k == 500) begin
                    repeat (200) @(negedge clk);
                    chk("R8 idle clocks keep window", 32'(init_busy), 32'(1));
                end
                strobe(k, win && k < WIN, win && k < WIN - 1, alc);
            end
            power_down();
        end

        // abort mid-window, then a fresh full window
        power_up(1'b0, 1'b0, 1'b1);
        for (int k = 0; k < 10; k++) strobe(k, 1'b1, 1'b1, 1'b1);
        power_down();
        @(negedge clk);
        smp_stb = 1'b1; din_l = 16'h1234; din_r = 16'h5678;
        @(negedge clk);
        smp_stb = 1'b0;
        chk("R7 strobe while off", 32'(dout_l), 32'(0));
        power_up(1'b0, 1'b0, 1'b1);
        for (int k = 0; k < WIN + 2; k++) strobe(k, k < WIN, k < WIN - 1, 1'b1);
        power_down();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule